// File: doc/BRIEF.md
# Trigger Input Deglitch Filter

This block conditions one raw trigger line before it reaches the rest of a chip. The raw level can first pass through a two-stage synchronizer to the local clock, or it can be taken as it is. One of several filter behaviours then shapes it, and a final XOR can invert the result. A single counter does all the timing for every behaviour, and a static mode code chooses the behaviour.

The configuration comes in on static ports: mode code, filter length, synchronizer enable and output inversion. In any filtering mode the result is held in a register. That register is written one clock edge after the deciding input sample. In pass-through mode the output follows the selected input through logic only, with no register. If the mode, length or synchronizer enable changes while the filter runs, the counter restarts from zero and the held level is kept.

Top module: `trig_in_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the held level clear to 0, so `dout` equals `out_inv` in every filtering mode.
- R2: Mode 3'b000 and the unused codes 3'b001, 3'b010 and 3'b011 pass the selected input to `dout` through logic only, with no added cycle.
- R3: With `sync_en` = 1, the selected input is `din` delayed by two clock edges. With `sync_en` = 0 it is `din` itself.
- R4: With `out_inv` = 1, `dout` is the complement of the level it would have with `out_inv` = 0.
- R5: In mode 3'b101 (delay), the held level takes a new input level at the L-th consecutive edge that samples that level, where L is `flt_len`. A length of 0 acts as 1.
- R6: In mode 3'b101, an input excursion sampled on fewer than L consecutive edges leaves the output unchanged.
- R7: In mode 3'b100 (rapid), the first edge that samples a level different from the held one updates the held level. The next L edges ignore the input.
- R8: In mode 3'b111 (stable-high), a rise needs L consecutive high samples, and a fall happens at the first edge that samples low.
- R9: In mode 3'b110 (stable-low), a fall needs L consecutive low samples, and a rise happens at the first edge that samples high.
- R10: A change of `mode`, `flt_len` or `sync_en` resets the counter to 0 at the next edge. The held level does not change on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Raw trigger input, may be asynchronous |
| sync_en | input | 1 | Enable the two-flop synchronizer |
| mode | input | 3 | Filter behaviour code |
| flt_len | input | LEN_W | Filter length in clock cycles |
| out_inv | input | 1 | Invert the final output |
| dout | output | 1 | Filtered trigger output |

## Verification
The embedded assertions check several properties on every cycle:
- reset clears the state;
- a pending delay or stable qualification never moves the held level early;
- the rapid-mode lockout keeps the held level fixed;
- stable-high falls and stable-low rises come through after one edge;
- a configuration change restarts the counter.

Only the bench scenarios show that qualification completes exactly at the L-th sample, that a length of 0 acts as 1, and that pass-through and inversion behave as required. The same holds for the two-edge synchronizer delay and for a length change made in the middle of a qualification postponing the output.

// File: rtl/trig_in_filter.sv
module trig_in_filter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             sync_en,
  input  logic [2:0]       mode,
  input  logic [LEN_W-1:0] flt_len,
  input  logic             out_inv,
  output logic             dout
);

  localparam logic [2:0] M_RAPID = 3'b100;
  localparam logic [2:0] M_DELAY = 3'b101;
  localparam logic [2:0] M_SLOW  = 3'b110;
  localparam logic [2:0] M_SHIGH = 3'b111;
  localparam int CFG_W = LEN_W + 4;
  localparam logic [LEN_W-1:0] ONE  = 1;
  localparam logic [LEN_W:0]   ONEW = 1;

  logic [1:0]       sync_q;
  logic [LEN_W-1:0] cnt;
  logic             held;
  logic [CFG_W-1:0] cfg_q;

  wire [CFG_W-1:0] cfg_now = {sync_en, mode, flt_len};
  wire             cfg_chg = cfg_now != cfg_q;
  wire             sel_in  = sync_en ? sync_q[1] : din;
  wire             differ  = sel_in != held;
  wire [LEN_W:0]   cnt_inc = {1'b0, cnt} + ONEW;
  wire             reached = cnt_inc >= {1'b0, flt_len};
  wire             fast    = (mode == M_SHIGH && !sel_in) || (mode == M_SLOW && sel_in);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      held  <= 1'b0;
      cfg_q <= cfg_now;
    end else if (cfg_chg) begin
      cfg_q <= cfg_now;
      cnt   <= '0;
    end else begin
      case (mode)
        M_RAPID: begin
          if (cnt != '0) begin
            cnt <= cnt - ONE;
          end else if (differ) begin
            held <= sel_in;
            cnt  <= flt_len;
          end
        end
        M_DELAY, M_SLOW, M_SHIGH: begin
          if (!differ) begin
            cnt <= '0;
          end else if (fast || reached) begin
            held <= sel_in;
            cnt  <= '0;
          end else begin
            cnt <= cnt_inc[LEN_W-1:0];
          end
        end
        default: begin
          held <= sel_in;
          cnt  <= '0;
        end
      endcase
    end
  end

  assign dout = (mode[2] ? held : sel_in) ^ out_inv;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (held == 1'b0 && cnt == '0));

  assert_delay_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg && mode == M_DELAY && differ && !reached) |=> $stable(held));

  assert_rapid_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg && mode == M_RAPID && cnt != '0) |=> $stable(held));

  assert_high_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg && mode == M_SHIGH && held && !sel_in) |=> !held);

  assert_low_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg && mode == M_SLOW && !held && sel_in) |=> held);

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (cnt == '0 && $stable(held)));

endmodule

// File: tb/trig_in_filter_tb_top.sv
module trig_in_filter_tb_top;
  logic clk = 1'b0;
  logic rst, din, sync_en, out_inv;
  logic [2:0]  mode;
  logic [11:0] flt_len;
  logic dout;

  typedef struct {
    logic  v;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  trig_in_filter #(.LEN_W(12)) dut_i (
    .clk(clk), .rst(rst), .din(din), .sync_en(sync_en), .mode(mode),
    .flt_len(flt_len), .out_inv(out_inv), .dout(dout)
  );

  // driver: set input at negedge, expect dout after the next posedge
  task automatic drv(input logic d, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    din = d;
    it.v = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drv_nc(input logic d);
    @(negedge clk);
    din = d;
  endtask

  task automatic setcfg(input logic [2:0] m, input logic [11:0] l, input logic s, input logic inv);
    @(negedge clk);
    mode = m; flt_len = l; sync_en = s; out_inv = inv;
  endtask

  // monitor: pop and compare after each posedge
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (dout !== it.v) begin
          fails++;
          $display("FAIL %s: dout=%b expected=%b at %0t", it.tag, dout, it.v, $time);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; din = 1'b0; mode = 3'b101; flt_len = 12'd3; sync_en = 1'b0; out_inv = 1'b0;
    repeat (3) drv_nc(1'b0);
    // R1: reset state, also with inversion
    setcfg(3'b101, 12'd3, 1'b0, 1'b1);
    drv(1'b1, 1'b1, "R1");
    setcfg(3'b101, 12'd3, 1'b0, 1'b0);
    drv(1'b0, 1'b0, "R1");
    @(negedge clk); rst = 1'b0;

    // R5: delay mode, L=3
    drv(1'b1, 1'b0, "R5");
    drv(1'b1, 1'b0, "R5");
    drv(1'b1, 1'b1, "R5");
    // R6: short low glitch ignored, then full-length low accepted
    drv(1'b0, 1'b1, "R6");
    drv(1'b0, 1'b1, "R6");
    drv(1'b1, 1'b1, "R6");
    drv(1'b0, 1'b1, "R6");
    drv(1'b0, 1'b1, "R6");
    drv(1'b0, 1'b0, "R5");

    // R7: rapid mode, L=3
    setcfg(3'b100, 12'd3, 1'b0, 1'b0);
    drv(1'b1, 1'b1, "R7");
    drv(1'b0, 1'b1, "R7");
    drv(1'b1, 1'b1, "R7");
    drv(1'b0, 1'b1, "R7");
    drv(1'b0, 1'b0, "R7");
    repeat (3) drv(1'b0, 1'b0, "R7");

    // R8: stable-high, L=2
    setcfg(3'b111, 12'd2, 1'b0, 1'b0);
    drv(1'b1, 1'b0, "R8");
    drv(1'b1, 1'b1, "R8");
    drv(1'b0, 1'b0, "R8");
    drv(1'b1, 1'b0, "R8");
    drv(1'b0, 1'b0, "R8");

    // R9: stable-low, L=2
    setcfg(3'b110, 12'd2, 1'b0, 1'b0);
    drv(1'b1, 1'b1, "R9");
    drv(1'b0, 1'b1, "R9");
    drv(1'b0, 1'b0, "R9");

    // R2: bypass and a reserved code
    setcfg(3'b000, 12'd3, 1'b0, 1'b0);
    drv(1'b1, 1'b1, "R2");
    drv(1'b0, 1'b0, "R2");
    setcfg(3'b010, 12'd3, 1'b0, 1'b0);
    drv(1'b1, 1'b1, "R2");

    // R4: inversion
    setcfg(3'b000, 12'd3, 1'b0, 1'b1);
    drv(1'b1, 1'b0, "R4");
    drv(1'b0, 1'b1, "R4");

    // R3: synchronizer adds two edges
    setcfg(3'b000, 12'd3, 1'b1, 1'b0);
    drv(1'b1, 1'b0, "R3");
    drv(1'b1, 1'b1, "R3");
    drv(1'b0, 1'b1, "R3");
    drv(1'b0, 1'b0, "R3");

    // R10: length change mid-qualification restarts counter
    setcfg(3'b101, 12'd3, 1'b0, 1'b0);
    repeat (4) drv_nc(1'b0);
    drv(1'b1, 1'b0, "R10");
    drv(1'b1, 1'b0, "R10");
    setcfg(3'b101, 12'd4, 1'b0, 1'b0);
    drv(1'b1, 1'b0, "R10");
    drv(1'b1, 1'b0, "R10");
    drv(1'b1, 1'b0, "R10");
    drv(1'b1, 1'b1, "R10");

    // R5: zero length acts as one
    setcfg(3'b101, 12'd0, 1'b0, 1'b0);
    drv(1'b0, 1'b0, "R5");

    @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule